// File: doc/BRIEF.md
# Table pointer program-memory access unit

This block moves single bytes between a byte-addressed program memory and a CPU's data space. A 22-bit pointer and an 8-bit latch are visible to software as four byte registers. A table-read command copies the byte the pointer selects into the latch. A table-write command copies the latch into one slot of a small holding buffer. Each of these two commands carries a pointer-update mode: keep, post-increment, post-decrement or pre-increment.

Two further commands act on whole blocks. A commit copies the full holding buffer into memory at the block the pointer's upper bits select, then refills the buffer with 0xFF. An erase sets a 64-byte block to 0xFF. Pointer bit 21 switches reads to a small configuration space, and it blocks commits and erases. Each command runs through a busy/done handshake: one cycle of busy, then a one-cycle done pulse.

The program memory is a simple register model of 2^MEM_AW bytes with no flash timing. Normal-space reads alias on pointer bits MEM_AW-1:0.

Top module: `tblacc_unit`

## Requirements
- R1: After reset the pointer and latch are 0, every memory byte and holding slot is 0xFF, and busy_o, done_o and err_o are low.
- R2: reg_sel_i selects a register: 0 is pointer bits 7:0, 1 is bits 15:8, 2 is bits 21:16 (read with bits 7:6 as 0, write keeps wdata 5:0), and 3 is the latch. reg_rdata_o shows the selected register. A write applies at the clock edge when reg_we_i is high and busy_o is low, and it is ignored while busy_o is high.
- R3: A command is accepted at an edge where cmd_valid_i is high and busy_o is low. busy_o is then high for exactly one cycle, and done_o pulses high in the cycle after. cmd_valid_i is ignored while busy_o is high.
- R4: cmd_op_i encodes 0 read, 1 write, 2 commit, 3 erase. For reads and writes, cmd_mode_i encodes 0 keep, 1 access then +1, 2 access then -1, and 3 +1 then access with the new value.
- R5: Pointer increment and decrement wrap within bits 20:0 and never change bit 21.
- R6: A read with bit 21 clear loads the memory byte at pointer bits MEM_AW-1:0 into the latch. With bit 21 set it loads 0xA0 OR pointer bits 3:0.
- R7: A write stores the latch into holding slot pointer[HOLD_IDX_W-1:0], whatever the upper bits are, and leaves memory unchanged.
- R8: A commit with bit 21 clear copies holding slot k to memory byte {pointer[MEM_AW-1:HOLD_IDX_W], k}. Every holding slot then reads back 0xFF.
- R9: An erase with bit 21 clear sets to 0xFF the 64 bytes whose address bits MEM_AW-1:6 equal pointer bits MEM_AW-1:6. Pointer bits 5:0 are ignored.
- R10: A commit or erase with bit 21 set raises err_o together with done_o. Memory, the holding buffer and the pointer are left unchanged.
- R11: Commits and erases ignore cmd_mode_i and leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | Command: 0 read, 1 write, 2 commit, 3 erase |
| cmd_mode_i | input | 2 | Pointer mode: 0 keep, 1 post-inc, 2 post-dec, 3 pre-inc |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejected commit/erase, valid with done_o |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected register value |
| ptr_o | output | 22 | Current pointer |

## Verification
A wrong pointer shows on ptr_o at the first edge after the command's execute cycle. A wrong holding slot or block address stays hidden until a later commit and a read-back, so the bench reads back every byte it commits and erases through the latch. A slip in the handshake shows on busy_o and done_o in the same cycle. A missed write lock shows on reg_rdata_o in the cycle after the write.

// File: rtl/tblacc_pkg.sv
package tblacc_pkg;
  localparam int PTR_W = 22;
  localparam int LOW_W = 21;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_COMMIT = 2'd2,
    OP_ERASE  = 2'd3
  } tbl_op_e;

  typedef enum logic [1:0] {
    PM_KEEP     = 2'd0,
    PM_POST_INC = 2'd1,
    PM_POST_DEC = 2'd2,
    PM_PRE_INC  = 2'd3
  } ptr_mode_e;

  typedef enum logic [1:0] {
    RS_LOW   = 2'd0,
    RS_HIGH  = 2'd1,
    RS_UPPER = 2'd2,
    RS_LATCH = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tblacc_ptr.sv
module tblacc_ptr
  import tblacc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       byte_we_i,
  input  logic [7:0]       wdata_i,
  input  logic             upd_en_i,
  input  ptr_mode_e        mode_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] eff_o
);
  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_dec, ptr_nxt;

  always_comb begin
    ptr_inc = {ptr_q[PTR_W-1], ptr_q[LOW_W-1:0] + LOW_W'(1)};
    ptr_dec = {ptr_q[PTR_W-1], ptr_q[LOW_W-1:0] - LOW_W'(1)};
    eff_o   = (mode_i == PM_PRE_INC) ? ptr_inc : ptr_q;
    unique case (mode_i)
      PM_KEEP:     ptr_nxt = ptr_q;
      PM_POST_DEC: ptr_nxt = ptr_dec;
      default:     ptr_nxt = ptr_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (upd_en_i) begin
      ptr_q <= ptr_nxt;
    end else begin
      if (byte_we_i[0]) ptr_q[7:0]   <= wdata_i;
      if (byte_we_i[1]) ptr_q[15:8]  <= wdata_i;
      if (byte_we_i[2]) ptr_q[21:16] <= wdata_i[5:0];
    end
  end

  assign ptr_o = ptr_q;

  // R5: configuration-space select survives every pointer step
  a_r5_bit21_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> (ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1])));

  a_r11_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_en_i && byte_we_i == 3'b000) |=> $stable(ptr_q));
endmodule

// File: rtl/tblacc_hold.sv
module tblacc_hold #(
  parameter int IDX_W = 5,
  localparam int NBYTES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        data_i,
  input  logic              clear_i,
  output logic [NBYTES*8-1:0] block_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
    logic [7:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   slot_q <= 8'hFF;
      else if (clear_i)              slot_q <= 8'hFF;
      else if (we_i && idx_i == SLOT) slot_q <= data_i;
    end
    assign block_o[g*8 +: 8] = slot_q;
  end

  a_r8_hold_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !we_i) |=> (block_o == {NBYTES*8{1'b1}}));
endmodule

// File: rtl/tblacc_mem.sv
module tblacc_mem #(
  parameter int MEM_AW = 9,
  parameter int IDX_W  = 5,
  localparam int MEM_BYTES = 1 << MEM_AW,
  localparam int HOLD_BYTES = 1 << IDX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_cfg_i,
  input  logic [MEM_AW-1:0]       rd_addr_i,
  output logic [7:0]              rd_data_o,
  input  logic                    commit_i,
  input  logic [MEM_AW-IDX_W-1:0] commit_blk_i,
  input  logic [HOLD_BYTES*8-1:0] block_i,
  input  logic                    erase_i,
  input  logic [MEM_AW-7:0]       erase_blk_i
);
  logic [7:0] mem_w [MEM_BYTES];

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_byte
    localparam logic [MEM_AW-1:0] ADDR = MEM_AW'(g);
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        byte_q <= 8'hFF;
      else if (erase_i && ADDR[MEM_AW-1:6] == erase_blk_i)
        byte_q <= 8'hFF;
      else if (commit_i && ADDR[MEM_AW-1:IDX_W] == commit_blk_i)
        byte_q <= block_i[int'(ADDR[IDX_W-1:0])*8 +: 8];
    end
    assign mem_w[g] = byte_q;
  end

  // configuration space: fixed pattern derived from the low nibble
  assign rd_data_o = rd_cfg_i ? {4'hA, rd_addr_i[3:0]} : mem_w[rd_addr_i];
endmodule

// File: rtl/tblacc_unit.sv
module tblacc_unit
  import tblacc_pkg::*;
#(
  parameter int MEM_AW     = 9,
  parameter int HOLD_IDX_W = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [1:0]  cmd_op_i,
  input  logic [1:0]  cmd_mode_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic [21:0] ptr_o
);
  localparam int HOLD_BYTES = 1 << HOLD_IDX_W;

  logic             busy_q, done_q, err_q;
  tbl_op_e          op_q;
  ptr_mode_e        mode_q;
  logic [7:0]       latch_q;
  logic [PTR_W-1:0] ptr, eff;
  logic [2:0]       byte_we;
  logic             reg_wr_ok, accept, upd_en, blk_op, cfg_sel;
  logic             hold_we, commit_go, erase_go, rej;
  logic [7:0]       rd_data;
  logic [HOLD_BYTES*8-1:0] block;

  assign reg_wr_ok = reg_we_i && !busy_q;
  assign accept    = cmd_valid_i && !busy_q;
  assign cfg_sel   = ptr[PTR_W-1];
  assign blk_op    = (op_q == OP_COMMIT) || (op_q == OP_ERASE);
  assign upd_en    = busy_q && !blk_op;
  assign hold_we   = busy_q && (op_q == OP_WRITE);
  assign commit_go = busy_q && (op_q == OP_COMMIT) && !cfg_sel;
  assign erase_go  = busy_q && (op_q == OP_ERASE) && !cfg_sel;
  assign rej       = busy_q && blk_op && cfg_sel;

  always_comb begin
    byte_we = 3'b000;
    if (reg_wr_ok && reg_sel_e'(reg_sel_i) != RS_LATCH) byte_we[reg_sel_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      op_q    <= OP_READ;
      mode_q  <= PM_KEEP;
      latch_q <= 8'h00;
    end else begin
      done_q <= busy_q;
      err_q  <= rej;
      if (busy_q) begin
        busy_q <= 1'b0;
        if (op_q == OP_READ) latch_q <= rd_data;
      end else begin
        if (reg_wr_ok && reg_sel_e'(reg_sel_i) == RS_LATCH) latch_q <= reg_wdata_i;
        if (accept) begin
          busy_q <= 1'b1;
          op_q   <= tbl_op_e'(cmd_op_i);
          mode_q <= ptr_mode_e'(cmd_mode_i);
        end
      end
    end
  end

  tblacc_ptr u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_we_i (byte_we),
    .wdata_i   (reg_wdata_i),
    .upd_en_i  (upd_en),
    .mode_i    (mode_q),
    .ptr_o     (ptr),
    .eff_o     (eff)
  );

  tblacc_hold #(.IDX_W(HOLD_IDX_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hold_we),
    .idx_i   (eff[HOLD_IDX_W-1:0]),
    .data_i  (latch_q),
    .clear_i (commit_go),
    .block_o (block)
  );

  tblacc_mem #(.MEM_AW(MEM_AW), .IDX_W(HOLD_IDX_W)) u_mem (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_cfg_i     (eff[PTR_W-1]),
    .rd_addr_i    (eff[MEM_AW-1:0]),
    .rd_data_o    (rd_data),
    .commit_i     (commit_go),
    .commit_blk_i (ptr[MEM_AW-1:HOLD_IDX_W]),
    .block_i      (block),
    .erase_i      (erase_go),
    .erase_blk_i  (ptr[MEM_AW-1:6])
  );

  always_comb begin
    unique case (reg_sel_e'(reg_sel_i))
      RS_LOW:   reg_rdata_o = ptr[7:0];
      RS_HIGH:  reg_rdata_o = ptr[15:8];
      RS_UPPER: reg_rdata_o = {2'b00, ptr[21:16]};
      default:  reg_rdata_o = latch_q;
    endcase
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign ptr_o  = ptr;

  a_r3_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o) |=> busy_o);
  a_r3_single_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (done_o && !busy_o));
  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  a_r2_latch_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q != OP_READ) |=> $stable(latch_q));
endmodule

// File: tb/sim_tblacc_unit.sv
module sim_tblacc_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0, cmd_mode = 2'd0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       busy, done, err;
  logic [7:0] rdata;
  logic [21:0] ptr;

  always #5 clk = ~clk;

  tblacc_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_mode_i(cmd_mode), .busy_o(busy), .done_o(done), .err_o(err),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .ptr_o(ptr)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  // reference model
  int m_ptr, m_latch, p_op, p_mode, m_mem[512], m_hold[32];
  bit m_busy, m_done, m_err;

  function automatic int inc21(int p);
    return (p & 'h200000) | ((p + 1) & 'h1FFFFF);
  endfunction
  function automatic int dec21(int p);
    return (p & 'h200000) | ((p - 1) & 'h1FFFFF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_latch = 0; m_busy = 0; m_done = 0; m_err = 0;
      foreach (m_mem[i]) m_mem[i] = 'hFF;
      foreach (m_hold[i]) m_hold[i] = 'hFF;
    end else begin
      m_done = 0; m_err = 0;
      if (m_busy) begin
        int a, base;
        m_busy = 0; m_done = 1;
        a = (p_mode == 3) ? inc21(m_ptr) : m_ptr;
        if (p_op < 2) begin
          if (p_op == 0) m_latch = (a & 'h200000) ? ('hA0 | (a & 'hF)) : m_mem[a & 511];
          else m_hold[a & 31] = m_latch;
          case (p_mode)
            1, 3: m_ptr = inc21(m_ptr);
            2: m_ptr = dec21(m_ptr);
            default: ;
          endcase
        end else if (m_ptr & 'h200000) begin
          m_err = 1;
        end else if (p_op == 2) begin
          base = m_ptr & 'h1E0;
          for (int k = 0; k < 32; k++) begin
            m_mem[base + k] = m_hold[k];
            m_hold[k] = 'hFF;
          end
        end else begin
          base = m_ptr & 'h1C0;
          for (int k = 0; k < 64; k++) m_mem[base + k] = 'hFF;
        end
      end else begin
        if (reg_we) case (reg_sel)
          0: m_ptr = (m_ptr & 'h3FFF00) | reg_wdata;
          1: m_ptr = (m_ptr & 'h3F00FF) | (reg_wdata << 8);
          2: m_ptr = (m_ptr & 'h00FFFF) | ((reg_wdata & 'h3F) << 16);
          default: m_latch = reg_wdata;
        endcase
        if (cmd_valid) begin m_busy = 1; p_op = cmd_op; p_mode = cmd_mode; end
      end
    end
  end

  task automatic chk(string f, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, f, act, exp);
    end
  endtask

  task automatic tick();
    int e;
    @(negedge clk);
    case (reg_sel)
      0: e = m_ptr & 'hFF;
      1: e = (m_ptr >> 8) & 'hFF;
      2: e = (m_ptr >> 16) & 'h3F;
      default: e = m_latch;
    endcase
    chk("busy", busy, m_busy);
    chk("done", done, m_done);
    chk("err", err, m_err);
    chk("ptr", ptr, m_ptr);
    chk("rdata", rdata, e);
  endtask

  task automatic reg_wr(int s, int d);
    reg_we = 1; reg_sel = 2'(s); reg_wdata = 8'(d);
    tick();
    reg_we = 0; reg_sel = 2'd3;
  endtask

  task automatic set_ptr(int p);
    reg_wr(0, p & 'hFF); reg_wr(1, (p >> 8) & 'hFF); reg_wr(2, (p >> 16) & 'hFF);
  endtask

  task automatic cmd(int op, int mode);
    cmd_valid = 1; cmd_op = 2'(op); cmd_mode = 2'(mode);
    tick();
    cmd_valid = 0;
    tick();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    reg_sel = 2'd3;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int s = 0; s < 4; s++) begin reg_sel = 2'(s); tick(); end
    reg_sel = 2'd3;
    cmd(0, 0);

    cur_req = "R2";
    reg_wr(0, 'h34); reg_wr(1, 'h12); reg_wr(2, 'hFF); reg_wr(3, 'h5A);
    for (int s = 0; s < 4; s++) begin reg_sel = 2'(s); tick(); end

    cur_req = "R7";
    set_ptr('h040);
    for (int i = 0; i < 32; i++) begin
      reg_wr(3, i * 7 + 3);
      cmd(1, 1);
    end
    set_ptr('h040);
    cmd(0, 0);

    cur_req = "R8";
    cmd(2, 1);
    for (int i = 0; i < 33; i++) cmd(0, 1);
    set_ptr('h060);
    cmd(2, 0);
    for (int i = 0; i < 4; i++) cmd(0, 1);

    cur_req = "R9";
    set_ptr('h045);
    cmd(3, 2);
    set_ptr('h03E);
    for (int i = 0; i < 6; i++) cmd(0, 1);

    cur_req = "R4";
    set_ptr('h050);
    reg_wr(3, 'hC3); cmd(1, 3);
    reg_wr(3, 'h3C); cmd(1, 2);
    cmd(1, 0);
    set_ptr('h040);
    cmd(2, 0);
    set_ptr('h04F);
    for (int i = 0; i < 4; i++) cmd(0, 3);
    cmd(0, 2); cmd(0, 2); cmd(0, 0);

    cur_req = "R5";
    set_ptr('h1FFFFF);
    cmd(0, 3);
    set_ptr('h200000);
    cmd(0, 2);
    cmd(0, 1);

    cur_req = "R6";
    set_ptr('h200005);
    for (int i = 0; i < 18; i++) cmd(0, 1);
    set_ptr('h100041);
    cmd(0, 0);

    cur_req = "R10";
    set_ptr('h200080);
    reg_wr(3, 'h77); cmd(1, 0);
    cmd(2, 1); cmd(3, 2);
    set_ptr('h080);
    cmd(0, 0);
    cmd(2, 0);
    cmd(0, 1);

    cur_req = "R11";
    set_ptr('h0C7);
    cmd(3, 3); cmd(2, 2);

    cur_req = "R3";
    cmd_valid = 1; cmd_op = 2'd0; cmd_mode = 2'd1;
    reg_we = 1; reg_sel = 2'd3; reg_wdata = 8'h99;
    tick();
    reg_we = 1; reg_sel = 2'd0; reg_wdata = 8'h11;
    tick();
    reg_we = 0; reg_sel = 2'd3;
    for (int i = 0; i < 5; i++) tick();
    cmd_valid = 0;
    tick(); tick();

    finish_run();
  end
endmodule